// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block models a byte-wide parallel NOR flash that is driven through a simple synchronous bus: an address, a write-data byte, a write strobe, a read strobe and a combinational read-data byte. Writes are interpreted as multi-cycle command sequences. Two fixed unlock writes guard every command, and the third write selects one of the following operations:

- program one byte;
- set up an erase (sector or whole array);
- enter the identification (autoselect) view;
- enter a bypass mode in which later commands need no unlock pair.

A separate single write enters a query view that returns a parameter table describing the array geometry.

Program and erase are timed: a cycle-count timer keeps the device busy while status bytes are returned on reads. An erase walks the affected range one byte per clock, writing 0xFF. When a program finishes, the device keeps showing its completion status. It falls back to plain array reads once enough consecutive reads have been made with no command under way. Each bus write to the array can only clear bits. The contents of a location go back to 1 only through an erase.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset the device is in read-array mode with bypass off, every array byte reads 0xFF, and a read returns the byte at the read address.
- R2: A command opens with 0xAA written at address UNLOCK0 followed by 0x55 at UNLOCK1. Any other write in either slot returns the device to read-array mode. Reads between unlock writes return array data.
- R3: The third write must be at UNLOCK0 unless bypass is on. Its data selects the command: 0xA0 program, 0x80 erase setup, 0x90 autoselect, 0x20 bypass entry. Any other value, or a wrong address, returns the device to read-array mode.
- R4: A program data write ANDs the data into the addressed byte. The device then stays busy for PROG_CYC cycles, and reads return {~d7, 7'b0}, where d7 is bit 7 of the written data. Writes are ignored while busy.
- R5: After a program completes, reads in read mode return {d7, 7'b0} for 43 consecutive reads, and array data from the 44th read on. Any write ends this status view.
- R6: After 0x80, a second unlock pair is needed. Then 0x10 at UNLOCK0 erases the whole array to 0xFF, and 0x30 at any address erases the sector addr[AW-1:SW] to 0xFF. Other sectors are left unchanged. Any other code or address returns the device to read-array mode.
- R7: While an erase runs, reads return 0x08 and every write is ignored, including 0xF0. A sector erase lasts SECT_CYC cycles and a chip erase lasts CHIP_CYC cycles. The device then reads array data.
- R8: In autoselect mode, reads return the following bytes. Any write other than the query entry leaves the mode.

  | Offset | Value |
  |--------|-------|
  | 0x00 | ID0 |
  | 0x01 | ID1 |
  | 0x02 | 0x00 |
  | 0x0E | ID2 |
  | 0x0F | ID3 |
  | any other | 0x00 |

- R9: Writing 0x98 at address 0x55 from read mode or autoselect mode enters query mode. In query mode, reads return a table, and any write returns the device to read-array mode. The table holds:
  - 0x51 0x52 0x59 at offsets 0x10 to 0x12;
  - 0x02 at 0x13 and 0x31 at 0x15;
  - AW at 0x27;
  - 0x01 at 0x2C;
  - the sector count minus 1 at 0x2D (low byte) and 0x2E (high byte);
  - the sector size divided by 256 at 0x2F (low byte) and 0x30 (high byte);
  - 0x50 0x52 0x49 at 0x31 to 0x33;
  - 0x00 at every other offset.
- R10: Writing 0xF0 in any non-busy state returns the device to read-array mode. The one exception is the program data slot, where 0xF0 is programmed as data.
- R11: In bypass mode, a write in read mode is taken as a command cycle at any address. A 0x90 command followed by a 0x00 write leaves bypass mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Byte address of the access |
| wdata | input | 8 | Write data or command byte |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, counted for the status fall-back |
| rdata | output | 8 | Read data for the current address and mode |

## Verification
Sequences are tried in several variants:
- correct unlock pairs;
- pairs corrupted in the address or data slot;
- a correct pair followed by a third write at a wrong address or with an unknown code.

These variants tell a guarded command apart from one that slipped through, because the addressed byte then either changes or does not. Program writes use data with bit 7 clear and with 0xF0. This separates the inverted busy status from the completion status, and a plain data byte from a reset command. Erases are issued as a sector erase, a chip erase, and a rejected final code. Reads are made inside and outside the affected sector, which shows whether the sector index is taken from the right address bits. A behavioural reference model is compared on every clock, so the exact cycle in which the busy period and the 43-read status window end is checked.

// File: rtl/nor_pkg.sv
package nor_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNLK_B,
        ST_CMD,
        ST_PROG_DATA,
        ST_ERS_A,
        ST_ERS_B,
        ST_ERS_CMD,
        ST_AUTOSEL,
        ST_QUERY,
        ST_PROG_BUSY,
        ST_ERS_BUSY
    } st_e;

    localparam logic [7:0] KEY_A       = 8'hAA;
    localparam logic [7:0] KEY_B       = 8'h55;
    localparam logic [7:0] OP_ERASE    = 8'h80;
    localparam logic [7:0] OP_IDENT    = 8'h90;
    localparam logic [7:0] OP_PROG     = 8'hA0;
    localparam logic [7:0] OP_BYPASS   = 8'h20;
    localparam logic [7:0] OP_CHIP     = 8'h10;
    localparam logic [7:0] OP_SECTOR   = 8'h30;
    localparam logic [7:0] OP_QUERY    = 8'h98;
    localparam logic [7:0] OP_RESET    = 8'hF0;
    localparam logic [7:0] OP_BYP_EXIT = 8'h00;
    localparam logic [7:0] QUERY_OFS   = 8'h55;
    localparam logic [7:0] ERASE_STAT  = 8'h08;
    localparam int         LAZY_LIMIT  = 42;

    // State reached by a command byte in the command slot.
    function automatic st_e cmd_target(input logic [7:0] c);
        case (c)
            OP_ERASE: return ST_ERS_A;
            OP_IDENT: return ST_AUTOSEL;
            OP_PROG:  return ST_PROG_DATA;
            default:  return ST_READ;
        endcase
    endfunction

    function automatic logic [7:0] ident_byte(input logic [7:0] ofs,
                                              input logic [7:0] i0, input logic [7:0] i1,
                                              input logic [7:0] i2, input logic [7:0] i3);
        case (ofs)
            8'h00:   return i0;
            8'h01:   return i1;
            8'h0E:   return i2;
            8'h0F:   return i3;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] query_byte(input logic [7:0] ofs, input int aw,
                                              input int nsect, input int ssize);
        case (ofs)
            8'h10: return 8'h51;
            8'h11: return 8'h52;
            8'h12: return 8'h59;
            8'h13: return 8'h02;
            8'h15: return 8'h31;
            8'h27: return 8'(aw);
            8'h2C: return 8'h01;
            8'h2D: return 8'(nsect - 1);
            8'h2E: return 8'((nsect - 1) >> 8);
            8'h2F: return 8'(ssize >> 8);
            8'h30: return 8'(ssize >> 16);
            8'h31: return 8'h50;
            8'h32: return 8'h52;
            8'h33: return 8'h49;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
    import nor_pkg::*;
#(
    parameter int          AW       = 8,
    parameter int          SW       = 6,
    parameter logic [15:0] UNLOCK0  = 16'h00AA,
    parameter logic [15:0] UNLOCK1  = 16'h0055,
    parameter int          PROG_CYC = 4,
    parameter int          SECT_CYC = 64,
    parameter int          CHIP_CYC = 640
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    input  logic          wr_en,
    input  logic          rd_en,
    output st_e           st,
    output logic          bypass,
    output logic          direct,
    output logic          last_prog,
    output logic          d7,
    output logic          prog_we,
    output logic          fill_we,
    output logic [AW-1:0] fill_addr
);
    localparam int            TW     = $clog2(CHIP_CYC + 1);
    localparam logic [AW-1:0] U0     = AW'(UNLOCK0);
    localparam logic [AW-1:0] U1     = AW'(UNLOCK1);
    localparam logic [AW-1:0] QOFS   = AW'(QUERY_OFS);
    localparam logic [SW-1:0] S_ONES = '1;

    logic [TW-1:0] tmr;
    logic [AW-1:0] ptr, ptr_end;
    logic          fill_on;
    logic [5:0]    lazy;

    wire at_u0  = (addr == U0);
    wire at_u1  = (addr == U1);
    wire is_qry = (addr == QOFS) && (wdata == OP_QUERY);
    wire busy   = (st == ST_PROG_BUSY) || (st == ST_ERS_BUSY);

    assign prog_we   = wr_en && (st == ST_PROG_DATA);
    assign fill_we   = fill_on;
    assign fill_addr = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_READ;
            bypass    <= 1'b0;
            direct    <= 1'b1;
            last_prog <= 1'b0;
            d7        <= 1'b0;
            tmr       <= '0;
            ptr       <= '0;
            ptr_end   <= '0;
            fill_on   <= 1'b0;
            lazy      <= '0;
        end else begin
            if (fill_on) begin
                ptr <= ptr + 1'b1;
                if (ptr == ptr_end) fill_on <= 1'b0;
            end
            if (busy) begin
                if (tmr == '0) begin
                    st <= ST_READ;
                    if (st == ST_ERS_BUSY) begin
                        direct <= 1'b1;
                    end else begin
                        last_prog <= 1'b1;
                        direct    <= 1'b0;
                        lazy      <= '0;
                    end
                end else begin
                    tmr <= tmr - 1'b1;
                end
            end else if (wr_en) begin
                direct    <= 1'b0;
                lazy      <= '0;
                last_prog <= 1'b0;
                if (wdata == OP_RESET && st != ST_PROG_DATA) begin
                    st <= ST_READ;
                end else begin
                    case (st)
                        ST_READ: begin
                            if (is_qry) st <= ST_QUERY;
                            else if (bypass) begin
                                st <= cmd_target(wdata);
                                if (wdata == OP_BYPASS) bypass <= 1'b1;
                            end else if (at_u0 && wdata == KEY_A) st <= ST_UNLK_B;
                            else st <= ST_READ;
                        end
                        ST_UNLK_B: st <= (at_u1 && wdata == KEY_B) ? ST_CMD : ST_READ;
                        ST_CMD: begin
                            if (!bypass && !at_u0) st <= ST_READ;
                            else begin
                                st <= cmd_target(wdata);
                                if (wdata == OP_BYPASS) bypass <= 1'b1;
                            end
                        end
                        ST_PROG_DATA: begin
                            d7  <= wdata[7];
                            tmr <= TW'(PROG_CYC - 1);
                            st  <= ST_PROG_BUSY;
                        end
                        ST_ERS_A: st <= (at_u0 && wdata == KEY_A) ? ST_ERS_B : ST_READ;
                        ST_ERS_B: st <= (at_u1 && wdata == KEY_B) ? ST_ERS_CMD : ST_READ;
                        ST_ERS_CMD: begin
                            if (wdata == OP_CHIP && at_u0) begin
                                ptr     <= '0;
                                ptr_end <= '1;
                                fill_on <= 1'b1;
                                tmr     <= TW'(CHIP_CYC - 1);
                                st      <= ST_ERS_BUSY;
                            end else if (wdata == OP_SECTOR) begin
                                ptr     <= {addr[AW-1:SW], {SW{1'b0}}};
                                ptr_end <= {addr[AW-1:SW], S_ONES};
                                fill_on <= 1'b1;
                                tmr     <= TW'(SECT_CYC - 1);
                                st      <= ST_ERS_BUSY;
                            end else begin
                                st <= ST_READ;
                            end
                        end
                        ST_AUTOSEL: begin
                            if (is_qry) st <= ST_QUERY;
                            else begin
                                if (bypass && wdata == OP_BYP_EXIT) bypass <= 1'b0;
                                st <= ST_READ;
                            end
                        end
                        default: st <= ST_READ;
                    endcase
                end
            end else if (rd_en && st == ST_READ && !direct) begin
                if (lazy == 6'(LAZY_LIMIT)) direct <= 1'b1;
                lazy <= lazy + 1'b1;
            end
        end
    end

endmodule

// File: rtl/nor_array.sv
module nor_array #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    input  logic          prog_we,
    input  logic          fill_we,
    input  logic [AW-1:0] fill_addr,
    output logic [7:0]    arr_q
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (fill_we) begin
            mem[fill_addr] <= 8'hFF;
        end else if (prog_we) begin
            mem[addr] <= mem[addr] & wdata;
        end
    end

    assign arr_q = mem[addr];

endmodule

// File: rtl/nor_rd_mux.sv
module nor_rd_mux
    import nor_pkg::*;
#(
    parameter int         AW  = 8,
    parameter int         SW  = 6,
    parameter logic [7:0] ID0 = 8'h01,
    parameter logic [7:0] ID1 = 8'h7E,
    parameter logic [7:0] ID2 = 8'h22,
    parameter logic [7:0] ID3 = 8'h01
) (
    input  st_e           st,
    input  logic          direct,
    input  logic          last_prog,
    input  logic          d7,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    arr_q,
    output logic [7:0]    rdata
);
    localparam int NSECT = 1 << (AW - SW);
    localparam int SSIZE = 1 << SW;

    wire [7:0] ofs = 8'(addr);

    always_comb begin
        case (st)
            ST_READ:      rdata = (last_prog && !direct) ? {d7, 7'b0} : arr_q;
            ST_AUTOSEL:   rdata = ident_byte(ofs, ID0, ID1, ID2, ID3);
            ST_QUERY:     rdata = query_byte(ofs, AW, NSECT, SSIZE);
            ST_PROG_BUSY: rdata = {~d7, 7'b0};
            ST_ERS_BUSY:  rdata = ERASE_STAT;
            default:      rdata = arr_q;
        endcase
    end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_pkg::*;
#(
    parameter int          AW       = 8,
    parameter int          SW       = 6,
    parameter logic [15:0] UNLOCK0  = 16'h00AA,
    parameter logic [15:0] UNLOCK1  = 16'h0055,
    parameter int          PROG_CYC = 4,
    parameter int          SECT_CYC = 64,
    parameter int          CHIP_CYC = 640,
    parameter logic [7:0]  ID0      = 8'h01,
    parameter logic [7:0]  ID1      = 8'h7E,
    parameter logic [7:0]  ID2      = 8'h22,
    parameter logic [7:0]  ID3      = 8'h01
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic [7:0]    rdata
);
    st_e           st;
    logic          bypass, direct, last_prog, d7, prog_we, fill_we;
    logic [AW-1:0] fill_addr;
    logic [7:0]    arr_q;

    nor_cmd_fsm #(
        .AW(AW), .SW(SW), .UNLOCK0(UNLOCK0), .UNLOCK1(UNLOCK1),
        .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)
    ) u_fsm (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
        .st(st), .bypass(bypass), .direct(direct), .last_prog(last_prog), .d7(d7),
        .prog_we(prog_we), .fill_we(fill_we), .fill_addr(fill_addr)
    );

    nor_array #(.AW(AW)) u_arr (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .prog_we(prog_we),
        .fill_we(fill_we), .fill_addr(fill_addr), .arr_q(arr_q)
    );

    nor_rd_mux #(
        .AW(AW), .SW(SW), .ID0(ID0), .ID1(ID1), .ID2(ID2), .ID3(ID3)
    ) u_mux (
        .st(st), .direct(direct), .last_prog(last_prog), .d7(d7),
        .addr(addr), .arr_q(arr_q), .rdata(rdata)
    );

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk
    import nor_pkg::*;
#(
    parameter int          AW       = 8,
    parameter logic [15:0] UNLOCK1  = 16'h0055,
    parameter int          CHIP_CYC = 640
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] addr,
    input logic [7:0]    wdata,
    input logic          wr_en,
    input logic [7:0]    rdata,
    input st_e           st,
    input logic          bypass,
    input logic          fill_we
);
    localparam int CW = $clog2(CHIP_CYC + 2);

    logic [CW-1:0] ers_len;

    always_ff @(posedge clk) begin
        if (rst) ers_len <= '0;
        else if (st == ST_ERS_BUSY) ers_len <= ers_len + 1'b1;
        else ers_len <= '0;
    end

    assert_unlock_abort_R2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_UNLK_B && wr_en && !(addr == AW'(UNLOCK1) && wdata == KEY_B))
        |=> st == ST_READ);

    assert_reset_cmd_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata == OP_RESET && st != ST_PROG_DATA &&
         st != ST_PROG_BUSY && st != ST_ERS_BUSY) |=> st == ST_READ);

    assert_erase_ignore_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ERS_BUSY && wr_en) |=> (st == ST_ERS_BUSY || st == ST_READ));

    assert_erase_len_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ERS_BUSY) |-> (ers_len < CW'(CHIP_CYC)));

    assert_erase_stat_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ERS_BUSY) |-> (rdata == ERASE_STAT));

    assert_fill_in_busy_R6: assert property (@(posedge clk) disable iff (rst)
        fill_we |-> (st == ST_ERS_BUSY));

    assert_prog_stat_R4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PROG_BUSY) |-> (rdata[6:0] == 7'b0));

    assert_bypass_entry_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(bypass) |-> ($past(wr_en) && $past(wdata) == OP_BYPASS));

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(
    .AW(AW), .UNLOCK1(UNLOCK1), .CHIP_CYC(CHIP_CYC)
) u_chk (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rdata(rdata),
    .st(st), .bypass(bypass), .fill_we(fill_we)
);

// File: tb/sim_nor_cmd_seq.sv
module sim_nor_cmd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8, SW = 6, PROG_CYC = 4, SECT_CYC = 64, CHIP_CYC = 640;
    localparam logic [7:0] U0 = 8'hAA, U1 = 8'h55;
    localparam logic [7:0] I0 = 8'h01, I1 = 8'h7E, I2 = 8'h22, I3 = 8'h01;

    logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic [7:0] rdata;
    int errors = 0, checks = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nor_cmd_seq #(.AW(AW), .SW(SW), .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC),
                  .CHIP_CYC(CHIP_CYC)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata));

    // Behavioural reference: mode numbers, instant erase, busy count-down.
    int md = 0, busy_left = 0, lazy = 0;
    bit byp = 0, direct = 1, lastp = 0, m_d7 = 0;
    logic [7:0] mem_m [256];

    function automatic logic [7:0] model_rd(input logic [7:0] a);
        case (md)
            0: return (lastp && !direct) ? {m_d7, 7'b0} : mem_m[a];
            7: case (a)
                   8'h00: return I0;  8'h01: return I1;
                   8'h0E: return I2;  8'h0F: return I3;
                   default: return 8'h00;
               endcase
            8: case (a)
                   8'h10: return 8'h51; 8'h11: return 8'h52; 8'h12: return 8'h59;
                   8'h13: return 8'h02; 8'h15: return 8'h31; 8'h27: return 8'(AW);
                   8'h2C: return 8'h01; 8'h2D: return 8'((1 << (AW - SW)) - 1);
                   8'h31: return 8'h50; 8'h32: return 8'h52; 8'h33: return 8'h49;
                   default: return 8'h00;
               endcase
            9:  return {~m_d7, 7'b0};
            10: return 8'h08;
            default: return mem_m[a];
        endcase
    endfunction

    function automatic string mode_tag();
        case (md)
            0: return (lastp && !direct) ? "R5" : "R1";
            3, 9: return "R4";
            7: return "R8";
            8: return "R9";
            10: return "R7";
            default: return "R2";
        endcase
    endfunction

    task automatic decode(input logic [7:0] d);
        case (d)
            8'h80: md = 4;
            8'h90: md = 7;
            8'hA0: md = 3;
            8'h20: begin byp = 1; md = 0; end
            default: md = 0;
        endcase
    endtask

    task automatic model_step(input logic [7:0] a, input logic [7:0] d, input bit w, input bit r);
        if (md == 9 || md == 10) begin
            if (busy_left == 0) begin
                if (md == 10) direct = 1;
                else begin lastp = 1; direct = 0; lazy = 0; end
                md = 0;
            end else busy_left--;
        end else if (w) begin
            direct = 0; lazy = 0; lastp = 0;
            if (d == 8'hF0 && md != 3) md = 0;
            else case (md)
                0: if (a == 8'h55 && d == 8'h98) md = 8;
                   else if (byp) decode(d);
                   else md = (a == U0 && d == 8'hAA) ? 1 : 0;
                1: md = (a == U1 && d == 8'h55) ? 2 : 0;
                2: if (!byp && a != U0) md = 0; else decode(d);
                3: begin mem_m[a] = mem_m[a] & d; m_d7 = d[7]; md = 9; busy_left = PROG_CYC - 1; end
                4: md = (a == U0 && d == 8'hAA) ? 5 : 0;
                5: md = (a == U1 && d == 8'h55) ? 6 : 0;
                6: if (d == 8'h10 && a == U0) begin
                       for (int i = 0; i < 256; i++) mem_m[i] = 8'hFF;
                       md = 10; busy_left = CHIP_CYC - 1;
                   end else if (d == 8'h30) begin
                       for (int i = 0; i < 256; i++) if ((i >> SW) == (int'(a) >> SW)) mem_m[i] = 8'hFF;
                       md = 10; busy_left = SECT_CYC - 1;
                   end else md = 0;
                7: if (a == 8'h55 && d == 8'h98) md = 8;
                   else begin if (byp && d == 8'h00) byp = 0; md = 0; end
                default: md = 0;
            endcase
        end else if (r && md == 0 && !direct) begin
            if (lazy == 42) direct = 1;
            lazy++;
        end
    endtask

    task automatic compare(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rdata=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // One bus cycle, starting and ending at a falling edge.
    task automatic cyc(input logic [7:0] a, input logic [7:0] d, input bit w, input bit r,
                       input bit chk, input logic [7:0] exp, input string tag);
        addr = a; wdata = d; wr_en = w; rd_en = r;
        #1;
        compare(rdata, model_rd(a), mode_tag());
        if (chk) compare(rdata, exp, tag);
        @(posedge clk);
        model_step(a, d, w, r);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cyc(a, d, 1, 0, 0, 8'h00, "");
    endtask
    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        cyc(a, 8'h00, 0, 1, 1, exp, tag);
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(8'h00, 8'h00, 0, 0, 0, 8'h00, "");
    endtask
    task automatic unlock();
        wr(U0, 8'hAA); wr(U1, 8'h55);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem_m[i] = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(8'h00, 8'hFF, "R1");
        rd(8'h80, 8'hFF, "R1");

        // R4 / R5: program with busy status, then 43-read status window
        unlock(); wr(U0, 8'hA0);
        rd(U1, 8'hFF, "R2");
        wr(8'h12, 8'h5A);
        rd(8'h12, 8'h80, "R4");
        wr(U0, 8'hAA);
        idle(PROG_CYC);
        rd(8'h12, 8'h00, "R5");
        for (int i = 0; i < 42; i++) cyc(8'h12, 8'h00, 0, 1, 0, 8'h00, "");
        rd(8'h12, 8'h5A, "R5");

        // R10: 0xF0 in the data slot is data; elsewhere it resets
        unlock(); wr(U0, 8'hA0); wr(8'h12, 8'hF0);
        idle(PROG_CYC + 1);
        wr(8'h00, 8'hF0);
        rd(8'h12, 8'h50, "R10");
        unlock(); wr(U0, 8'hF0); wr(8'h12, 8'h00);
        rd(8'h12, 8'h50, "R10");

        // R2: broken unlock pairs
        wr(U0, 8'hAA); wr(8'h56, 8'h55); wr(U0, 8'hA0); wr(8'h12, 8'h00);
        rd(8'h12, 8'h50, "R2");
        wr(U0, 8'hAA); wr(U1, 8'h54); wr(U0, 8'hA0); wr(8'h12, 8'h00);
        rd(8'h12, 8'h50, "R2");

        // R3: wrong third address and unknown code
        unlock(); wr(8'h13, 8'hA0); wr(8'h12, 8'h00);
        rd(8'h12, 8'h50, "R3");
        unlock(); wr(U0, 8'h77); wr(8'h12, 8'h00);
        rd(8'h12, 8'h50, "R3");

        // R8 / R9: autoselect, query from autoselect, query from read
        unlock(); wr(U0, 8'h90);
        rd(8'h00, I0, "R8"); rd(8'h01, I1, "R8"); rd(8'h02, 8'h00, "R8");
        rd(8'h0E, I2, "R8"); rd(8'h0F, I3, "R8"); rd(8'h05, 8'h00, "R8");
        wr(8'h55, 8'h98);
        rd(8'h10, 8'h51, "R9"); rd(8'h11, 8'h52, "R9"); rd(8'h12, 8'h59, "R9");
        rd(8'h27, 8'd8, "R9"); rd(8'h2D, 8'h03, "R9"); rd(8'h33, 8'h49, "R9");
        wr(8'h00, 8'h00);
        rd(8'h12, 8'h50, "R9");
        wr(8'h55, 8'h98);
        rd(8'h13, 8'h02, "R9");
        wr(8'h00, 8'hF0);
        unlock(); wr(U0, 8'h90); wr(8'h00, 8'h12);
        rd(8'h12, 8'h50, "R8");

        // R6 / R7: sector erase of sector 0, other sector kept
        unlock(); wr(U0, 8'hA0); wr(8'h50, 8'h00); idle(PROG_CYC + 1);
        unlock(); wr(U0, 8'h80); unlock(); wr(8'h20, 8'h30);
        rd(8'h12, 8'h08, "R7");
        wr(U0, 8'hAA); wr(8'h00, 8'hF0);
        rd(8'h00, 8'h08, "R7");
        idle(SECT_CYC);
        rd(8'h12, 8'hFF, "R6"); rd(8'h3F, 8'hFF, "R6"); rd(8'h50, 8'h00, "R6");

        // R6: rejected final erase codes
        unlock(); wr(U0, 8'h80); unlock(); wr(U0, 8'h40);
        rd(8'h50, 8'h00, "R6");
        unlock(); wr(U0, 8'h80); unlock(); wr(8'h01, 8'h10);
        rd(8'h50, 8'h00, "R6");

        // R11: bypass entry, unguarded program, exit
        unlock(); wr(U0, 8'h20);
        wr(8'h03, 8'hA0); wr(8'h70, 8'h0F); idle(PROG_CYC + 1);
        wr(8'h00, 8'hF0);
        rd(8'h70, 8'h0F, "R11");
        wr(8'h10, 8'h90);
        rd(8'h00, I0, "R11");
        wr(8'h10, 8'h00);
        wr(8'h03, 8'hA0); wr(8'h71, 8'h00);
        rd(8'h71, 8'hFF, "R11");

        // R7: chip erase from bypass mode
        unlock(); wr(U0, 8'h20);
        wr(8'h00, 8'h80); unlock(); wr(U0, 8'h10);
        rd(8'h70, 8'h08, "R7");
        idle(CHIP_CYC - 2);
        rd(8'h70, 8'h08, "R7");
        rd(8'h70, 8'hFF, "R7");
        rd(8'h50, 8'hFF, "R6");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule